// File: doc/BRIEF.md
# Reset Sequencer with Strap Capture

This block generates the internal reset and the instruction-fetch enable for a small processor subsystem. It accepts two reset sources. One is an active-low external pin that forces reset at once, without a clock edge. The other is a single-cycle watchdog request that is synchronous to the master clock. Leaving reset always happens on a master-clock edge. The pin's release first passes through a short synchronizer chain. A watchdog reset is held for a fixed stretch before it is released.

After the internal reset lifts, a counter keeps the fetch enable low. The total delay from the pin's rising edge to the first fetch is a fixed, parameterised number of clock edges. A pin reset also samples two configuration straps, a boot-mode code and a tri-state request, at the edge where its release completes. A watchdog reset leaves both latched values untouched. A two-bit cause output records which source produced the most recent reset. The pin always wins over a watchdog request that arrives while the pin reset is still active.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `ext_rst_n_i` is low, `core_rst_n_o` and `fetch_en_o` are 0, `rst_cause_o` is 2'b01, and `boot_mode_o` and `tri_req_o` are 0. This takes effect as soon as the pin falls, with no clock edge needed.
- R2: After the pin rises, `core_rst_n_o` stays low through the first SYNC_STAGES-1 rising clock edges. It goes high right after edge number SYNC_STAGES (edge 2 by default).
- R3: After a pin release, `fetch_en_o` goes high right after rising edge number FETCH_DLY (80 by default), counted from the pin's rising edge. It then stays high until the next reset of either kind.
- R4: On a pin reset, `boot_mode_o` and `tri_req_o` take the values of `boot_strap_i` and `tri_strap_i` sampled at edge SYNC_STAGES after release. Later changes on those inputs have no effect.
- R5: A watchdog pulse sampled at edge w while `core_rst_n_o` is high makes `core_rst_n_o` low after edges w to w+WDOG_STRETCH-1, and high again after edge w+WDOG_STRETCH (w+4 by default). `fetch_en_o` is low from edge w and rises after edge w+WDOG_STRETCH+FETCH_DLY-SYNC_STAGES (w+82 by default).
- R6: A watchdog reset leaves `boot_mode_o` and `tri_req_o` unchanged, even when the strap inputs carry different values at that time.
- R7: `rst_cause_o` reads 2'b01 after a pin reset and 2'b10 after a watchdog reset. It changes at each reset entry.
- R8: A watchdog pulse is ignored while the pin is low, or while the pin's release is still passing through the synchronizer. In that case the cause stays 2'b01, the straps follow the pin, and the release timing matches a plain pin reset.
- R9: `clk_out_en_o` is high during reset and after it.
- R10: The pin must be held low for at least MIN_LOW_CLKS (10) rising clock edges before its release. A shorter low period is flagged.
- R11: A second watchdog pulse during a watchdog stretch reloads the stretch. Release then happens WDOG_STRETCH edges after the second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous assertion |
| wdog_req_i | input | 1 | Watchdog reset request, one-cycle synchronous pulse |
| boot_strap_i | input | BOOT_W | Boot-mode strap input |
| tri_strap_i | input | 1 | Tri-state request strap input |
| core_rst_n_o | output | 1 | Internal reset, active low |
| fetch_en_o | output | 1 | Registered instruction-fetch enable |
| clk_out_en_o | output | 1 | Enable for driving the master-clock image out |
| boot_mode_o | output | BOOT_W | Latched boot-mode strap |
| tri_req_o | output | 1 | Latched tri-state request strap |
| rst_cause_o | output | 2 | Last reset source: 2'b01 pin, 2'b10 watchdog |

## Verification
Pin resets sweep every boot-mode code against both tri-state values. Each release then flips the strap inputs after capture, which separates a correct capture edge from a late or continuous sample. Watchdog pulses are applied singly and in back-to-back pairs, with the strap inputs changed beforehand. These runs separate the stretch length and reload from the fetch delay, and show that the straps are left alone. Watchdog pulses placed during the pin's low phase and in its synchronizer window tell a correctly prioritised pin apart from a watchdog that overrides it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [1:0] {
      CAUSE_PIN  = 2'b01,
      CAUSE_WDOG = 2'b10
   } rst_cause_e;
endpackage

// File: rtl/rstseq_sync.sv
// Release synchronizer: every stage is cleared asynchronously while the
// pin is low and fills with ones, one stage per clock edge, after release.
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic rel_o,
   output logic rel_next_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic d;
         if (i == 0) begin : g_head
            assign d = 1'b1;
         end else begin : g_tail
            assign d = stage_q[i-1];
         end
         always_ff @(posedge clk_i or negedge arst_n_i) begin
            if (!arst_n_i) stage_q[i] <= 1'b0;
            else           stage_q[i] <= d;
         end
      end
   endgenerate

   assign rel_o      = stage_q[STAGES-1];
   assign rel_next_o = stage_q[STAGES-2];
endmodule

// File: rtl/rstseq_stretch.sv
// Holds active_o for LEN cycles after an arm pulse; a new arm reloads.
module rstseq_stretch #(
   parameter int LEN = 4
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic arm_i,
   output logic active_o
);
   localparam int CW = $clog2(LEN + 1);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("rstseq_stretch: LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i)           left_q <= '0;
      else if (arm_i)          left_q <= CW'(LEN);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign active_o = (left_q != '0);
endmodule

// File: rtl/rstseq_fetch_gate.sv
// Counts WAIT cycles of hold_i low, then raises a registered enable that
// stays up until hold_i returns.
module rstseq_fetch_gate #(
   parameter int WAIT = 78
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic hold_i,
   output logic en_o
);
   localparam int CW = $clog2(WAIT) + 1;

   generate
      if (WAIT < 1) begin : g_bad_wait
         $error("rstseq_fetch_gate: WAIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          en_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (hold_i) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (!en_q) begin
         if (cnt_q == CW'(WAIT - 1)) en_q  <= 1'b1;
         else                        cnt_q <= cnt_q + 1'b1;
      end
   end

   assign en_o = en_q;
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int FETCH_DLY    = 80,
   parameter int WDOG_STRETCH = 4,
   parameter int BOOT_W       = 2
) (
   input  logic              clk_i,
   input  logic              ext_rst_n_i,
   input  logic              wdog_req_i,
   input  logic [BOOT_W-1:0] boot_strap_i,
   input  logic              tri_strap_i,
   output logic              core_rst_n_o,
   output logic              fetch_en_o,
   output logic              clk_out_en_o,
   output logic [BOOT_W-1:0] boot_mode_o,
   output logic              tri_req_o,
   output logic [1:0]        rst_cause_o
);
   localparam int FETCH_WAIT = FETCH_DLY - SYNC_STAGES;

   generate
      if (FETCH_WAIT < 1) begin : g_bad_fetch
         $error("rstseq_ctrl: FETCH_DLY must exceed SYNC_STAGES");
      end
      if (BOOT_W < 1) begin : g_bad_boot
         $error("rstseq_ctrl: BOOT_W must be at least 1");
      end
   endgenerate

   logic pin_rel;
   logic pin_rel_nxt;
   logic wd_accept;
   logic wd_active;
   logic gate_hold;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i      (clk_i),
      .arst_n_i   (ext_rst_n_i),
      .rel_o      (pin_rel),
      .rel_next_o (pin_rel_nxt)
   );

   // Pin priority: a watchdog request counts only once the pin release is done.
   assign wd_accept = wdog_req_i & pin_rel;

   rstseq_stretch #(.LEN(WDOG_STRETCH)) u_wd (
      .clk_i    (clk_i),
      .arst_n_i (ext_rst_n_i),
      .arm_i    (wd_accept),
      .active_o (wd_active)
   );

   assign core_rst_n_o = pin_rel & ~wd_active;
   assign gate_hold    = ~core_rst_n_o | wd_accept;

   rstseq_fetch_gate #(.WAIT(FETCH_WAIT)) u_gate (
      .clk_i    (clk_i),
      .arst_n_i (ext_rst_n_i),
      .hold_i   (gate_hold),
      .en_o     (fetch_en_o)
   );

   // Strap capture on the edge that completes a pin release.
   always_ff @(posedge clk_i or negedge ext_rst_n_i) begin
      if (!ext_rst_n_i) begin
         boot_mode_o <= '0;
         tri_req_o   <= 1'b0;
      end else if (pin_rel_nxt && !pin_rel) begin
         boot_mode_o <= boot_strap_i;
         tri_req_o   <= tri_strap_i;
      end
   end

   always_ff @(posedge clk_i or negedge ext_rst_n_i) begin
      if (!ext_rst_n_i)   rst_cause_o <= CAUSE_PIN;
      else if (wd_accept) rst_cause_o <= CAUSE_WDOG;
   end

   assign clk_out_en_o = 1'b1;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk #(
   parameter int BOOT_W       = 2,
   parameter int MIN_LOW_CLKS = 10
) (
   input logic              clk_i,
   input logic              ext_rst_n_i,
   input logic              wdog_req_i,
   input logic              core_rst_n_o,
   input logic              fetch_en_o,
   input logic [BOOT_W-1:0] boot_mode_o,
   input logic              tri_req_o,
   input logic [1:0]        rst_cause_o
);
   logic [7:0] low_cnt_q;
   logic       pin_prev_q;

   always_ff @(posedge clk_i) begin
      pin_prev_q <= ext_rst_n_i;
      if (ext_rst_n_i)               low_cnt_q <= '0;
      else if (low_cnt_q != 8'hFF)   low_cnt_q <= low_cnt_q + 1'b1;
   end

   always @(posedge clk_i) begin
      if (ext_rst_n_i && pin_prev_q === 1'b0)
         AST_MIN_LOW_CLKS: assert (low_cnt_q >= 8'(MIN_LOW_CLKS)); // R10
      if (!ext_rst_n_i)
         AST_PIN_FORCES_RST: assert (!core_rst_n_o && !fetch_en_o && rst_cause_o == 2'b01); // R1
   end

   AST_RELEASE_AFTER_PIN: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      $rose(core_rst_n_o) |-> $past(ext_rst_n_i)); // R2
   AST_FETCH_NEEDS_CORE: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      fetch_en_o |-> core_rst_n_o); // R3
   AST_FETCH_STAYS: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      (fetch_en_o && !wdog_req_i) |=> fetch_en_o); // R3
   AST_STRAPS_HELD: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      (core_rst_n_o && $past(core_rst_n_o)) |-> ($stable(boot_mode_o) && $stable(tri_req_o))); // R4
   AST_WD_ENTERS_RST: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      (wdog_req_i && core_rst_n_o) |=> (!core_rst_n_o && !fetch_en_o)); // R5
   AST_WD_KEEPS_STRAPS: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      (wdog_req_i && core_rst_n_o) |=> ($stable(boot_mode_o) && $stable(tri_req_o))); // R6
   AST_WD_CAUSE: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      (wdog_req_i && core_rst_n_o) |=> (rst_cause_o == 2'b10)); // R7
   AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
      $onehot(rst_cause_o)); // R7
endmodule

bind rstseq_ctrl rstseq_ctrl_chk #(.BOOT_W(BOOT_W)) chk_i (
   .clk_i        (clk_i),
   .ext_rst_n_i  (ext_rst_n_i),
   .wdog_req_i   (wdog_req_i),
   .core_rst_n_o (core_rst_n_o),
   .fetch_en_o   (fetch_en_o),
   .boot_mode_o  (boot_mode_o),
   .tri_req_o    (tri_req_o),
   .rst_cause_o  (rst_cause_o)
);

// File: tb/rstseq_ctrl_tb_top.sv
module rstseq_ctrl_tb_top;
   localparam int SYNC    = 2;
   localparam int FDLY    = 80;
   localparam int STRETCH = 4;
   localparam int BW      = 2;
   localparam int LOWMIN  = 10;

   logic          clk = 1'b0;
   logic          ext_rst_n;
   logic          wdog_req;
   logic [BW-1:0] boot_strap;
   logic          tri_strap;
   logic          core_rst_n;
   logic          fetch_en;
   logic          clk_out_en;
   logic [BW-1:0] boot_mode;
   logic          tri_req;
   logic [1:0]    rst_cause;

   int vecs = 0;
   int fails = 0;
   int edge_n = 0;
   int core_lo, core_hi, fet_lo, fet_hi, strap_edge;
   logic [BW-1:0] boot_old, boot_new;
   logic          tri_old, tri_new;
   logic [1:0]    cause_exp;

   always #2 clk = ~clk;

   rstseq_ctrl #(
      .SYNC_STAGES(SYNC), .FETCH_DLY(FDLY), .WDOG_STRETCH(STRETCH), .BOOT_W(BW)
   ) dut_i (
      .clk_i(clk), .ext_rst_n_i(ext_rst_n), .wdog_req_i(wdog_req),
      .boot_strap_i(boot_strap), .tri_strap_i(tri_strap),
      .core_rst_n_o(core_rst_n), .fetch_en_o(fetch_en), .clk_out_en_o(clk_out_en),
      .boot_mode_o(boot_mode), .tri_req_o(tri_req), .rst_cause_o(rst_cause)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at edge %0d: actual %0h expected %0h", req, edge_n, act, exp);
      end
   endtask

   // One clock edge, then compare every output against the arithmetic model.
   task automatic step(input string tag);
      @(posedge clk);
      edge_n++;
      @(negedge clk);
      wdog_req = 1'b0;
      chk({tag, " core_rst_n"}, 32'(core_rst_n), 32'(!(edge_n >= core_lo && edge_n < core_hi)));
      chk({tag, " fetch_en R3"}, 32'(fetch_en), 32'(!(edge_n >= fet_lo && edge_n < fet_hi)));
      chk("R7 cause", 32'(rst_cause), 32'(cause_exp));
      chk("R4 boot_mode", 32'(boot_mode), 32'(edge_n >= strap_edge ? boot_new : boot_old));
      chk("R4 tri_req", 32'(tri_req), 32'(edge_n >= strap_edge ? tri_new : tri_old));
      chk("R9 clk_out_en", 32'(clk_out_en), 32'd1);
   endtask

   task automatic pin_cycle(input logic [BW-1:0] b, input logic t,
                            input bit wd_low, input bit wd_sync);
      int low_edges;
      @(negedge clk);
      ext_rst_n = 1'b0;
      #1;
      chk("R1 async core", 32'(core_rst_n), 32'd0);
      chk("R1 async fetch", 32'(fetch_en), 32'd0);
      chk("R1 async cause", 32'(rst_cause), 32'd1);
      chk("R1 async straps", 32'({boot_mode, tri_req}), 32'd0);
      low_edges = 0;
      for (int i = 0; i < LOWMIN + 2; i++) begin
         if (wd_low && i == 4) wdog_req = 1'b1;
         @(posedge clk);
         low_edges++;
         @(negedge clk);
         wdog_req = 1'b0;
         chk("R1 R8 held core", 32'(core_rst_n), 32'd0);
         chk("R8 cause while low", 32'(rst_cause), 32'd1);
         chk("R9 clk_out_en low", 32'(clk_out_en), 32'd1);
      end
      chk("R10 low edges", 32'(low_edges >= LOWMIN), 32'd1);
      boot_strap = b;
      tri_strap  = t;
      ext_rst_n  = 1'b1;
      edge_n     = 0;
      core_lo = 0; core_hi = SYNC;
      fet_lo  = 0; fet_hi  = FDLY;
      strap_edge = SYNC;
      boot_old = '0; boot_new = b;
      tri_old  = 1'b0; tri_new = t;
      cause_exp = 2'b01;
      if (wd_sync) wdog_req = 1'b1;
      for (int i = 0; i < FDLY + 4; i++) begin
         step(wd_sync ? "R8 R2" : "R2");
         if (edge_n == SYNC) begin
            boot_strap = ~b;
            tri_strap  = ~t;
         end
      end
      boot_old = boot_new;
      tri_old  = tri_new;
   endtask

   task automatic wd_test(input int gap2);
      int w;
      boot_strap = ~boot_new;
      tri_strap  = ~tri_new;
      wdog_req   = 1'b1;
      w = edge_n + 1;
      core_lo = w; core_hi = w + STRETCH;
      fet_lo  = w; fet_hi  = w + STRETCH + FDLY - SYNC;
      cause_exp = 2'b10;
      step("R5");
      if (gap2 > 0) begin
         for (int i = 1; i < gap2; i++) step("R5");
         wdog_req = 1'b1;
         w = edge_n + 1;
         core_hi = w + STRETCH;
         fet_hi  = w + STRETCH + FDLY - SYNC;
         step("R11");
         for (int i = 0; i < STRETCH + 1; i++) step("R11");
      end
      while (edge_n < fet_hi + 2) step("R5");
      chk("R6 boot kept", 32'(boot_mode), 32'(boot_new));
      chk("R6 tri kept", 32'(tri_req), 32'(tri_new));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin : main
      ext_rst_n  = 1'b1;
      wdog_req   = 1'b0;
      boot_strap = '0;
      tri_strap  = 1'b0;
      #1 ext_rst_n = 1'b0;
      #0.5;
      chk("R1 reset core", 32'(core_rst_n), 32'd0);
      chk("R1 reset fetch", 32'(fetch_en), 32'd0);
      chk("R1 reset cause", 32'(rst_cause), 32'd1);
      chk("R9 reset clk_out_en", 32'(clk_out_en), 32'd1);
      for (int b = 0; b < (1 << BW); b++)
         for (int t = 0; t < 2; t++)
            pin_cycle(BW'(b), t[0], 1'b0, 1'b0);
      wd_test(0);
      wd_test(2);
      wd_test(3);
      pin_cycle(BW'(2), 1'b1, 1'b1, 1'b0);
      pin_cycle(BW'(1), 1'b0, 1'b0, 1'b1);
      wd_test(0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule